// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors and a chooser that picks between them for each branch address. The global component indexes a table of two-bit counters with a shift register of recent outcomes from all branches. The local component first reads a per-address table of outcome histories, then uses that history to index a table of three-bit counters. The chooser is a per-address table of two-bit counters whose upper half selects the global component.

A fetch stage presents a PC on the lookup port. One cycle later the block returns the direction, plus the global history, local history and both component guesses that produced it. When the branch resolves, the pipeline returns the PC, the real outcome and those saved values on the update port. The block then trains the counters that produced the guess, shifts the outcome into the global history, and shifts it into that address's local history.

Top module: `tourn_bp`

## Requirements
- R1: After synchronous reset, every two-bit counter holds 1, every three-bit counter holds 3, and all histories are zero. A first lookup returns taken=0, both component guesses 0, and both returned histories 0.
- R2: `pred_valid` is high in exactly the cycle after a cycle with `lk_valid` high. The prediction outputs hold their value when `lk_valid` is low. A lookup sees the state from before any update in the same cycle.
- R3: A two-bit counter predicts taken when its value is 2 or more. A three-bit counter predicts taken when its value is 4 or more. Each counter increments on taken and decrements on not taken, saturating at 0 and at its maximum. `pred_glob` is the guess of the global counter.
- R4: The global counter table (2^GHIST_W entries) is indexed by the global history register. On each update that register shifts left and takes the outcome (1 = taken) into bit 0. `pred_ghist` returns the register value used at lookup.
- R5: The local history table (2^LHT_IDX_W entries of LHIST_W bits) is indexed by PC bits [PC_LSB +: LHT_IDX_W]. On update, the addressed entry shifts left and takes the outcome into bit 0. `pred_lhist` returns the entry read at lookup.
- R6: The local guess `pred_loc` is the taken test of the three-bit counter indexed by the local history value read at lookup.
- R7: The chooser entry is indexed by PC bits [PC_LSB +: CHOOSE_IDX_W], and its value being 2 or more selects the global guess for `pred_taken`. It trains only when `up_glob` differs from `up_loc`. It increments when `up_glob` equals the outcome and decrements otherwise.
- R8: Training writes the global counter at `up_ghist` and the local counter at `up_lhist`, the values supplied on the update port. It does not use the histories current at update time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch PC of the lookup |
| pred_valid | output | 1 | Prediction outputs are fresh |
| pred_taken | output | 1 | Final direction guess |
| pred_ghist | output | GHIST_W | Global history used by the lookup |
| pred_lhist | output | LHIST_W | Local history used by the lookup |
| pred_glob | output | 1 | Global component guess |
| pred_loc | output | 1 | Local component guess |
| up_valid | input | 1 | Resolved branch update |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome (1 = taken) |
| up_ghist | input | GHIST_W | Global history saved at lookup |
| up_lhist | input | LHIST_W | Local history saved at lookup |
| up_glob | input | 1 | Global guess saved at lookup |
| up_loc | input | 1 | Local guess saved at lookup |

## Verification
Each prediction output is due one clock edge after its lookup. An update changes the tables on its own edge, so its effect first shows in a lookup issued in the next cycle. The reference model evaluates each posedge: it forms the expected outputs from its state before that edge's update, then applies the update. The bench compares the model with the outputs at the following negedge, which keeps every check one register stage after its stimulus. It also covers a lookup and an update issued in the same cycle, where the model must show the state from before the update.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // saturating step of an up/down counter held as an integer
  function automatic int sat_next(int cur, int maxv, logic up);
    if (up) return (cur >= maxv) ? maxv : cur + 1;
    else    return (cur <= 0) ? 0 : cur - 1;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXV  = (1 << CTR_W) - 1;

  logic [CTR_W-1:0] mem [DEPTH];

  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_W'(INIT);
    end else if (wr_en) begin
      mem[wr_idx] <= CTR_W'(tbp_pkg::sat_next(int'(mem[wr_idx]), MAXV, wr_up));
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && mem[wr_idx] == CTR_W'(MAXV)) |=> mem[$past(wr_idx)] == CTR_W'(MAXV)); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up && mem[wr_idx] == '0) |=> mem[$past(wr_idx)] == '0); // R3
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {mem[wr_idx][HIST_W-2:0], wr_bit};
    end
  end

  AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_idx)] == {$past(mem[wr_idx][HIST_W-2:0]), $past(wr_bit)}); // R5
endmodule

// File: rtl/tourn_bp.sv
module tourn_bp #(
  parameter int PC_W         = 32,
  parameter int PC_LSB       = 2,
  parameter int CHOOSE_IDX_W = 10,
  parameter int GHIST_W      = 10,
  parameter int LHT_IDX_W    = 8,
  parameter int LHIST_W      = 10,
  parameter int GCTR_W       = 2,
  parameter int LCTR_W       = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               pred_valid,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] pred_ghist,
  output logic [LHIST_W-1:0] pred_lhist,
  output logic               pred_glob,
  output logic               pred_loc,
  input  logic               up_valid,
  input  logic [PC_W-1:0]    up_pc,
  input  logic               up_taken,
  input  logic [GHIST_W-1:0] up_ghist,
  input  logic [LHIST_W-1:0] up_lhist,
  input  logic               up_glob,
  input  logic               up_loc
);
  localparam int CH_W     = 2;
  localparam int CH_INIT  = 1;
  localparam int G_INIT   = 1;
  localparam int L_INIT   = (1 << (LCTR_W - 1)) - 1;

  logic [GHIST_W-1:0]      ghr;
  logic [CHOOSE_IDX_W-1:0] lk_ch_idx, up_ch_idx;
  logic [LHT_IDX_W-1:0]    lk_lht_idx, up_lht_idx;
  logic [LHIST_W-1:0]      lk_lhist;
  logic [CH_W-1:0]         lk_chctr;
  logic [GCTR_W-1:0]       lk_gctr;
  logic [LCTR_W-1:0]       lk_lctr;
  logic                    use_glob_q;

  assign lk_ch_idx  = lk_pc[PC_LSB +: CHOOSE_IDX_W];
  assign up_ch_idx  = up_pc[PC_LSB +: CHOOSE_IDX_W];
  assign lk_lht_idx = lk_pc[PC_LSB +: LHT_IDX_W];
  assign up_lht_idx = up_pc[PC_LSB +: LHT_IDX_W];

  logic unused_bits;
  assign unused_bits = ^{lk_pc, up_pc, lk_chctr[0], lk_gctr[GCTR_W-2:0], lk_lctr[LCTR_W-2:0]};

  // chooser: trains only on disagreement
  bp_ctr_table #(.IDX_W(CHOOSE_IDX_W), .CTR_W(CH_W), .INIT(CH_INIT)) u_chooser (
    .clk(clk), .rst(rst), .rd_idx(lk_ch_idx), .rd_ctr(lk_chctr),
    .wr_en(up_valid && (up_glob != up_loc)), .wr_idx(up_ch_idx), .wr_up(up_glob == up_taken));

  // global component, indexed by outcome history
  bp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .INIT(G_INIT)) u_glob (
    .clk(clk), .rst(rst), .rd_idx(ghr), .rd_ctr(lk_gctr),
    .wr_en(up_valid), .wr_idx(up_ghist), .wr_up(up_taken));

  // local component: per-address history, then counter table
  bp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst(rst), .rd_idx(lk_lht_idx), .rd_hist(lk_lhist),
    .wr_en(up_valid), .wr_idx(up_lht_idx), .wr_bit(up_taken));

  bp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(L_INIT)) u_loc (
    .clk(clk), .rst(rst), .rd_idx(lk_lhist), .rd_ctr(lk_lctr),
    .wr_en(up_valid), .wr_idx(up_lhist), .wr_up(up_taken));

  always_ff @(posedge clk) begin
    if (rst) ghr <= '0;
    else if (up_valid) ghr <= {ghr[GHIST_W-2:0], up_taken};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_ghist <= '0;
      pred_lhist <= '0;
      pred_glob  <= 1'b0;
      pred_loc   <= 1'b0;
      use_glob_q <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_ghist <= ghr;
        pred_lhist <= lk_lhist;
        pred_glob  <= lk_gctr[GCTR_W-1];
        pred_loc   <= lk_lctr[LCTR_W-1];
        use_glob_q <= lk_chctr[CH_W-1];
        pred_taken <= lk_chctr[CH_W-1] ? lk_gctr[GCTR_W-1] : lk_lctr[LCTR_W-1];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid && $stable(pred_taken)); // R2
  AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> ghr == {$past(ghr[GHIST_W-2:0]), $past(up_taken)}); // R4
  AST_CHOICE: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> pred_taken == (use_glob_q ? pred_glob : pred_loc)); // R7
endmodule

// File: tb/test_tourn_bp.sv
`timescale 1ns/1ps
module test_tourn_bp;
  localparam int NCH = 1024, NG = 1024, NLHT = 256, NL = 1024;

  logic        clk = 0, rst = 1;
  logic        lk_valid = 0, up_valid = 0, up_taken = 0, up_glob = 0, up_loc = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic [9:0]  up_ghist = 0, up_lhist = 0;
  logic        pred_valid, pred_taken, pred_glob, pred_loc;
  logic [9:0]  pred_ghist, pred_lhist;

  int n_tests = 0, n_fail = 0;

  tourn_bp i_tourn_bp (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_ghist(pred_ghist),
    .pred_lhist(pred_lhist), .pred_glob(pred_glob), .pred_loc(pred_loc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_ghist(up_ghist),
    .up_lhist(up_lhist), .up_glob(up_glob), .up_loc(up_loc));

  always #2 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model
  int m_ch[NCH], m_g[NG], m_l[NL], m_lht[NLHT], m_ghr;
  int e_valid, e_taken, e_gh, e_lh, e_g, e_l;

  function automatic int sat(int v, int mx, logic up);
    if (up) return (v < mx) ? v + 1 : mx;
    return (v > 0) ? v - 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) m_ch[i] = 1;
      for (int i = 0; i < NG; i++) m_g[i] = 1;
      for (int i = 0; i < NL; i++) m_l[i] = 3;
      for (int i = 0; i < NLHT; i++) m_lht[i] = 0;
      m_ghr = 0; e_valid = 0; e_taken = 0; e_gh = 0; e_lh = 0; e_g = 0; e_l = 0;
    end else begin
      e_valid = int'(lk_valid);
      if (lk_valid) begin
        int ci, li;
        ci = int'((lk_pc >> 2) & 32'(NCH - 1));
        li = int'((lk_pc >> 2) & 32'(NLHT - 1));
        e_gh = m_ghr;
        e_lh = m_lht[li];
        e_g = (m_g[e_gh] >= 2) ? 1 : 0;
        e_l = (m_l[e_lh] >= 4) ? 1 : 0;
        e_taken = (m_ch[ci] >= 2) ? e_g : e_l;
      end
      if (up_valid) begin
        int ci, li;
        ci = int'((up_pc >> 2) & 32'(NCH - 1));
        li = int'((up_pc >> 2) & 32'(NLHT - 1));
        m_g[int'(up_ghist)] = sat(m_g[int'(up_ghist)], 3, up_taken);   // R8
        m_l[int'(up_lhist)] = sat(m_l[int'(up_lhist)], 7, up_taken);   // R8
        if (up_glob != up_loc) m_ch[ci] = sat(m_ch[ci], 3, up_glob == up_taken);
        m_lht[li] = ((m_lht[li] << 1) | int'(up_taken)) & (NL - 1);
        m_ghr = ((m_ghr << 1) | int'(up_taken)) & (NG - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "pred_valid", int'(pred_valid), e_valid);
      chk("R2", "pred_taken held/new", int'(pred_taken), e_taken);
      chk("R7", "pred_taken", int'(pred_taken), e_taken);
      chk("R4", "pred_ghist", int'(pred_ghist), e_gh);
      chk("R5", "pred_lhist", int'(pred_lhist), e_lh);
      chk("R3", "pred_glob", int'(pred_glob), e_g);
      chk("R6", "pred_loc", int'(pred_loc), e_l);
    end
  end

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; up_valid = 0;
  endtask

  // lookup, then update with the returned values
  task automatic branch(logic [31:0] pc, logic t);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc; up_valid = 0;
    @(negedge clk);
    lk_valid = 0;
    up_valid = 1; up_pc = pc; up_taken = t;
    up_ghist = pred_ghist; up_lhist = pred_lhist; up_glob = pred_glob; up_loc = pred_loc;
    @(negedge clk);
    up_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: first lookup after reset
    @(negedge clk); lk_valid = 1; lk_pc = 32'h40;
    @(negedge clk); lk_valid = 0;
    chk("R1", "reset taken", int'(pred_taken), 0);
    chk("R1", "reset glob", int'(pred_glob), 0);
    chk("R1", "reset loc", int'(pred_loc), 0);
    chk("R1", "reset ghist", int'(pred_ghist), 0);
    chk("R1", "reset lhist", int'(pred_lhist), 0);
    idle();
    // loop branch: 7 taken then exit, repeated (R3 saturation, R5, R6)
    for (int r = 0; r < 12; r++)
      for (int k = 0; k < 8; k++) branch(32'h1000, k != 7);
    // correlated pair: second outcome copies the first (R4, R7)
    for (int r = 0; r < 60; r++) begin
      logic x;
      x = 1'($urandom);
      branch(32'h2004, x);
      branch(32'h2010, x);
    end
    // long not-taken run drives counters to zero (R3)
    for (int k = 0; k < 12; k++) branch(32'h3000, 1'b0);
    // stale history and forced disagreement on update port (R8, R7)
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      lk_valid = 1'($urandom); lk_pc = 32'($urandom) & 32'hFFC;
      up_valid = 1; up_pc = 32'($urandom) & 32'hFFC; up_taken = 1'($urandom);
      up_ghist = 10'($urandom); up_lhist = 10'($urandom);
      up_glob = 1'($urandom); up_loc = 1'($urandom);
    end
    idle();
    // same-cycle lookup and update of one address: pre-update state (R2)
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      lk_valid = 1; lk_pc = 32'h1000;
      up_valid = 1; up_pc = 32'h1000; up_taken = 1;
      up_ghist = pred_ghist; up_lhist = pred_lhist; up_glob = ~pred_loc; up_loc = pred_loc;
    end
    idle();
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++) branch(32'h1000, k != 7);
    idle(); idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule